// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Recognition and Vectoring Unit

This unit sits beside the retire stage of a processor core. At every instruction boundary, marked by a retire strobe, it looks at the pending events and decides whether the core should leave its current instruction stream. The events are a programmed exception raised by the retiring instruction, a nonmaskable interrupt, a single-step debug trap, and a maskable interrupt. When an event wins, the unit reports which one it was, its vector number and the byte address of its entry in a 256-entry table of 32-bit handler pointers. It also asks for the processor state to be pushed onto the system stack, in the same way as for a call, and returns the updated flag bits.

The flag register, the vector table, the stack memory and the instruction decoder are all outside this block. The unit reads the current interrupt-enable, trap and resume flags on its inputs. It returns their new values together with a write strobe, which the owner of the flag register applies. The nonmaskable line is edge-triggered and stays latched until it is serviced. The maskable line is a level.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, accept_o, push_o and flag_we_o are 0, and vector_o, vec_addr_o, cause_o and flags_o are all 0.
- R2: A maskable request (intr_i high at a retire) is accepted only when ie_i is 1. It is then reported one clock after the retire with vector_o equal to intr_vec_i and cause_o = 3.
- R3: A rising edge on nmi_i is latched until it is serviced, with or without a retire in the same cycle. It is accepted at the first retire at which no exception is requested, whatever the value of ie_i, with vector 2 and cause_o = 1. One edge is serviced exactly once.
- R4: At a retire with tf_i = 1 and rf_i = 0, and no higher-priority event, a single-step trap is accepted with vector 1 and cause_o = 2.
- R5: At a retire with rf_i = 1, no trap is raised. The unit strobes flag_we_o with flags_o[2] (resume) = 0 one clock later, and flags_o[1:0] equal to {tf_i, ie_i} when nothing is accepted.
- R6: When several events are present at one retire, they are served in this order: programmed exception (cause 0, vector exc_vec_i), then nonmaskable, then trap, then maskable. An event that loses stays available for a later retire.
- R7: vec_addr_o equals vector_o times 4, which is the byte offset of a 4-byte table entry (16-bit segment plus 16-bit offset). For example, vector 0xFF gives 0x3FC.
- R8: An accept is a one-cycle pulse of accept_o and push_o in the clock after the retire. In that same cycle flag_we_o = 1 and flags_o = 3'b000, where flags_o[0] is interrupt enable, [1] is trap and [2] is resume.
- R9: Without retire_i, nothing is accepted and no flag write is made. A latched nonmaskable event stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | Instruction boundary strobe |
| intr_i | input | 1 | Maskable request level |
| intr_vec_i | input | VEC_W | Vector number of the maskable request |
| nmi_i | input | 1 | Nonmaskable request, rising-edge sensitive |
| exc_req_i | input | 1 | Programmed exception from the retiring instruction |
| exc_vec_i | input | VEC_W | Vector number of the exception |
| ie_i | input | 1 | Current interrupt-enable flag |
| tf_i | input | 1 | Current trap flag |
| rf_i | input | 1 | Current resume flag |
| accept_o | output | 1 | Event accepted (one-cycle pulse) |
| push_o | output | 1 | Request to push state onto the stack |
| cause_o | output | 2 | 0 exception, 1 nonmaskable, 2 trap, 3 maskable |
| vector_o | output | VEC_W | Selected vector number |
| vec_addr_o | output | VEC_W+2 | Byte address of the table entry |
| flag_we_o | output | 1 | Write strobe for flags_o |
| flags_o | output | 3 | New flags {resume, trap, enable} |

## Verification
The only hidden state is the latched nonmaskable event. If it is lost, it shows up at the first later retire as a missing cause-1 accept. If it is kept too long, the next retire shows a second, spurious cause-1 accept. A bad priority decision or a wrong flag result appears at the ports one clock after the retire that caused it. So a reference model compared on every clock localises each fault to a single boundary. The bench also runs directed sequences that build up simultaneous events and that hold a nonmaskable edge across idle cycles and across exceptions.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    CAUSE_EXC  = 2'd0,
    CAUSE_NMI  = 2'd1,
    CAUSE_TRAP = 2'd2,
    CAUSE_MASK = 2'd3
  } cause_e;

  localparam int unsigned N_CAUSE = 4;

  typedef struct packed {
    logic rf;
    logic tf;
    logic ie;
  } flags_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic active_o
);
  logic prev_q, pend_q, rise;

  assign rise     = nmi_i & ~prev_q;
  assign active_o = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= active_o & ~take_i;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]            req_i,
  input  logic [N_SRC-1:0][VEC_W-1:0] vec_i,
  output logic                        valid_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [VEC_W-1:0]            vec_o
);
  // index 0 is the highest priority
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    vec_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        vec_o   = vec_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_flag_next.sv
module irq_flag_next
  import irq_vec_pkg::*;
(
  input  logic   retire_i,
  input  logic   accept_i,
  input  flags_t cur_i,
  output flags_t nxt_o,
  output logic   we_o
);
  always_comb begin
    nxt_o    = cur_i;
    nxt_o.rf = 1'b0;
    if (accept_i) begin
      nxt_o.ie = 1'b0;
      nxt_o.tf = 1'b0;
    end
    we_o = retire_i & (accept_i | cur_i.rf);
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned TRAP_VEC = 1,
  parameter int unsigned NMI_VEC  = 2,
  localparam int unsigned ENTRY_BYTES = 4,
  localparam int unsigned ADDR_W = VEC_W + $clog2(ENTRY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              intr_i,
  input  logic [VEC_W-1:0]  intr_vec_i,
  input  logic              nmi_i,
  input  logic              exc_req_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  input  logic              ie_i,
  input  logic              tf_i,
  input  logic              rf_i,
  output logic              accept_o,
  output logic              push_o,
  output logic [1:0]        cause_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              flag_we_o,
  output logic [2:0]        flags_o
);
  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic                          nmi_active;
  logic [N_CAUSE-1:0]            req;
  logic [N_CAUSE-1:0][VEC_W-1:0] vecs;
  logic                          win;
  logic [1:0]                    win_idx;
  logic [VEC_W-1:0]              win_vec;
  logic                          take;
  flags_t                        cur_flags, nxt_flags;
  logic                          nxt_we;

  assign take = retire_i & win;

  irq_nmi_edge i_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_i   (nmi_i),
    .take_i  (take && (win_idx == CAUSE_NMI)),
    .active_o(nmi_active)
  );

  always_comb begin
    req                = '0;
    req[CAUSE_EXC]     = exc_req_i;
    req[CAUSE_NMI]     = nmi_active;
    req[CAUSE_TRAP]    = tf_i & ~rf_i;
    req[CAUSE_MASK]    = intr_i & ie_i;
    vecs               = '0;
    vecs[CAUSE_EXC]    = exc_vec_i;
    vecs[CAUSE_NMI]    = VEC_W'(NMI_VEC);
    vecs[CAUSE_TRAP]   = VEC_W'(TRAP_VEC);
    vecs[CAUSE_MASK]   = intr_vec_i;
  end

  irq_arbiter #(.N_SRC(N_CAUSE), .VEC_W(VEC_W)) i_arb (
    .req_i  (req),
    .vec_i  (vecs),
    .valid_o(win),
    .idx_o  (win_idx),
    .vec_o  (win_vec)
  );

  assign cur_flags = '{rf: rf_i, tf: tf_i, ie: ie_i};

  irq_flag_next i_flags (
    .retire_i(retire_i),
    .accept_i(take),
    .cur_i   (cur_flags),
    .nxt_o   (nxt_flags),
    .we_o    (nxt_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      push_o     <= 1'b0;
      cause_o    <= '0;
      vector_o   <= '0;
      vec_addr_o <= '0;
      flag_we_o  <= 1'b0;
      flags_o    <= '0;
    end else begin
      accept_o  <= take;
      push_o    <= take;
      flag_we_o <= nxt_we;
      if (take) begin
        cause_o    <= win_idx;
        vector_o   <= win_vec;
        vec_addr_o <= {win_vec, {SHIFT{1'b0}}};
      end
      if (nxt_we) flags_o <= nxt_flags;
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int unsigned VEC_W = 8,
  localparam int unsigned ADDR_W = VEC_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_i,
  input logic              intr_i,
  input logic [VEC_W-1:0]  intr_vec_i,
  input logic              nmi_i,
  input logic              exc_req_i,
  input logic [VEC_W-1:0]  exc_vec_i,
  input logic              ie_i,
  input logic              tf_i,
  input logic              rf_i,
  input logic              accept_o,
  input logic              push_o,
  input logic [1:0]        cause_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              flag_we_o,
  input logic [2:0]        flags_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_accept_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> push_o && flag_we_o && (flags_o == 3'b000));

  p_accept_after_retire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && accept_o) |-> $past(retire_i));

  p_mask_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && accept_o && cause_o == 2'd3) |-> $past(ie_i && intr_i));

  p_nmi_vector_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && cause_o == 2'd1) |-> vector_o == VEC_W'(2));

  p_trap_cond_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && accept_o && cause_o == 2'd2) |-> $past(tf_i && !rf_i));

  p_exc_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(retire_i && exc_req_i)) |-> accept_o && cause_o == 2'd0);

  p_table_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> vec_addr_o == {vector_o, 2'b00});

  p_resume_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(retire_i && rf_i)) |-> flag_we_o && !flags_o[2]);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.VEC_W(VEC_W)) i_chk (.*);

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/100ps
module test_irq_vector_unit;
  localparam int VW = 8;

  logic clk = 0, rst_n = 0;
  logic retire = 0, intr = 0, nmi = 0, exc = 0, ie = 0, tf = 0, rf = 0;
  logic [VW-1:0] intr_vec = 0, exc_vec = 0;
  logic accept, push, flag_we;
  logic [1:0] cause;
  logic [VW-1:0] vector;
  logic [VW+1:0] vaddr;
  logic [2:0] flags;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_vector_unit #(.VEC_W(VW)) i_irq_vector_unit (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .intr_i(intr), .intr_vec_i(intr_vec),
    .nmi_i(nmi), .exc_req_i(exc), .exc_vec_i(exc_vec), .ie_i(ie), .tf_i(tf), .rf_i(rf),
    .accept_o(accept), .push_o(push), .cause_o(cause), .vector_o(vector),
    .vec_addr_o(vaddr), .flag_we_o(flag_we), .flags_o(flags));

  // behavioural reference
  int m_prev = 0, m_pend = 0;
  int e_acc = 0, e_cause = 0, e_vec = 0, e_we = 0, e_flags = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_pend = 0; e_acc = 0; e_cause = 0; e_vec = 0; e_we = 0; e_flags = 0;
    end else begin
      int nmi_now, sel;
      nmi_now = m_pend || (nmi && !m_prev);
      sel = -1;
      if (retire) begin
        if (exc) sel = 0;
        else if (nmi_now) sel = 1;
        else if (tf && !rf) sel = 2;
        else if (intr && ie) sel = 3;
      end
      m_pend = (sel == 1) ? 0 : nmi_now;
      m_prev = nmi;
      e_acc = (sel >= 0);
      if (sel >= 0) begin
        e_cause = sel;
        e_vec = (sel == 0) ? exc_vec : (sel == 1) ? 2 : (sel == 2) ? 1 : intr_vec;
      end
      e_we = retire && (sel >= 0 || rf);
      if (e_we) e_flags = (sel >= 0) ? 0 : {1'b0, tf, ie};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8 model accept", accept, e_acc);
    chk("R8 model push", push, e_acc);
    chk("R6 model cause", cause, e_cause);
    chk("R6 model vector", vector, e_vec);
    chk("R7 model addr", vaddr, e_vec * 4);
    chk("R5 model flag_we", flag_we, e_we);
    chk("R5 model flags", flags, e_flags);
  end

  task automatic step(input logic r, input logic i, input logic n, input logic x,
                      input logic e, input logic t, input logic s);
    retire = r; intr = i; nmi = n; exc = x; ie = e; tf = t; rf = s;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 accept", accept, 0); chk("R1 flag_we", flag_we, 0);
    chk("R1 vector", vector, 0); chk("R1 flags", flags, 0);
    // R2 masked, then enabled
    intr_vec = 8'h45;
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R2 masked", accept, 0);
    step(1, 1, 0, 0, 1, 0, 0);
    chk("R2 accept", accept, 1); chk("R2 vector", vector, 8'h45); chk("R2 cause", cause, 3);
    chk("R7 addr", vaddr, 10'h114);
    chk("R8 flags", flags, 0); chk("R8 we", flag_we, 1); chk("R8 push", push, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8 pulse", accept, 0);
    // R3, R9: NMI edge latched across idle cycles
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9 no retire", accept, 0); chk("R9 no we", flag_we, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R3 accept", accept, 1); chk("R3 vector", vector, 2); chk("R3 cause", cause, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R3 once", accept, 0);
    // R4, R5
    step(1, 0, 0, 0, 1, 1, 0);
    chk("R4 accept", accept, 1); chk("R4 vector", vector, 1); chk("R4 cause", cause, 2);
    step(1, 0, 0, 0, 1, 1, 1);
    chk("R5 no trap", accept, 0); chk("R5 we", flag_we, 1); chk("R5 flags", flags, 3'b011);
    step(0, 0, 0, 0, 0, 0, 0);
    // R6 all at once
    exc_vec = 8'h80; intr_vec = 8'h21;
    step(1, 1, 1, 1, 1, 1, 0);
    chk("R6 exc first", cause, 0); chk("R6 exc vec", vector, 8'h80);
    step(1, 1, 1, 0, 1, 1, 0);
    chk("R6 nmi second", cause, 1); chk("R6 nmi acc", accept, 1);
    step(1, 1, 0, 0, 1, 1, 0);
    chk("R6 trap third", cause, 2);
    step(1, 1, 0, 0, 1, 0, 0);
    chk("R6 mask last", cause, 3); chk("R6 mask vec", vector, 8'h21);
    // R7 top vector
    exc_vec = 8'hFF;
    step(1, 0, 0, 1, 0, 0, 0);
    chk("R7 max addr", vaddr, 10'h3FC);
    step(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule